// File: doc/BRIEF.md
# Level-1 Cache/SRAM Partition Decoder

This block sits in front of a 32 KiB level-1 memory whose space is shared between a cache and directly addressed SRAM. A 3-bit mode value sets how much of the memory serves as cache. The cache part is always taken from the top of the offset space and grows downward. Whatever lies below it is SRAM. Each access offset is classified against that boundary. An SRAM hit reports the offset unchanged. A hit in the cache region reports the offset measured from the boundary.

The block also applies the write policy. In the program-memory variant the processor may only read, and writes must come from one of the two DMA initiators. In the data-memory variant every initiator may read and write. The processor can always reload the mode value. The cache arrays, tags and line fill lie outside this block. A direct access that falls in the cache region is flagged and dropped.

Top module: `l1_partition_dec`

## Requirements
- R1: After reset the mode holds 7 (all cache). Any access is then decoded as a cache-region hit, with index equal to the offset, and flagged.
- R2: Mode codes map to cache sizes as follows: 0 gives none, 1 gives 4 KiB, 2 gives 8 KiB, 3 gives 16 KiB, and 4 to 7 give 32 KiB. The boundary is 32768 minus the cache size.
- R3: An offset below the boundary is an SRAM hit, and index_o equals the offset. sram_hit_o and cache_hit_o are never both high.
- R4: An offset at or above the boundary is a cache-region hit with index_o = offset − boundary. It sets viol_o, and acc_o stays low.
- R5: In the program variant, a write whose source is the processor (code 0) or reserved (code 3) sets viol_o and is dropped, even in SRAM.
- R6: Reads from any source, and writes from external DMA (code 1) or internal DMA (code 2), that hit SRAM set acc_o without viol_o.
- R7: A mode write takes effect in the cycle after cfg_we_i. A request presented in the same cycle as the write is decoded with the old mode.
- R8: All decode outputs are registered one cycle after the request. With no request valid, acc_o, viol_o, sram_hit_o, cache_hit_o and index_o are all zero.
- R9: In the data variant (PROG_VARIANT=0), processor writes that hit SRAM are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_mode_i | input | 3 | New mode value |
| req_valid_i | input | 1 | Access request present |
| req_src_i | input | 2 | Initiator: 0 processor, 1 external DMA, 2 internal DMA, 3 reserved |
| req_we_i | input | 1 | Access is a write |
| req_off_i | input | 15 | Byte offset into the memory |
| acc_o | output | 1 | Access accepted |
| viol_o | output | 1 | Access violated policy and was dropped |
| sram_hit_o | output | 1 | Access fell in the SRAM region |
| cache_hit_o | output | 1 | Access fell in the cache region |
| index_o | output | 15 | Offset local to the selected region |

## Verification
The assertions assume that every request field is a defined value in any cycle where req_valid_i is high. They also assume that cfg_mode_i is defined whenever cfg_we_i is high. The random stimulus draws all request and mode fields every cycle, so this always holds, and it mixes mode writes into the same cycles as requests. Offsets are biased toward the current boundary and its neighbours, so that both sides of every split are exercised.

// File: rtl/l1pd_pkg.sv
package l1pd_pkg;
  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_EDMA = 2'd1,
    SRC_IDMA = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/l1pd_mode_reg.sv
module l1pd_mode_reg #(
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= '1;  // all cache out of reset
    else if (we_i) mode_o <= mode_i;
  end
endmodule

// File: rtl/l1pd_bound.sv
module l1pd_bound #(
  parameter int AW       = 15,
  parameter int MIN_LOG2 = 12,
  parameter int MODE_W   = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [AW:0]       bound_o
);
  localparam int STEPS = AW - MIN_LOG2;
  localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

  logic [AW:0] cache_sz;

  always_comb begin
    if (mode_i == '0)              cache_sz = '0;
    else if (int'(mode_i) > STEPS) cache_sz = FULL;
    else                           cache_sz = FULL >> (STEPS + 1 - int'(mode_i));
  end

  assign bound_o = FULL - cache_sz;
endmodule

// File: rtl/l1pd_region.sv
module l1pd_region #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] off_i,
  input  logic [AW:0]   bound_i,
  output logic          sram_o,
  output logic [AW-1:0] idx_o
);
  assign sram_o = {1'b0, off_i} < bound_i;
  assign idx_o  = sram_o ? off_i : off_i - bound_i[AW-1:0];
endmodule

// File: rtl/l1pd_policy.sv
module l1pd_policy
  import l1pd_pkg::*;
#(
  parameter bit PROG_VARIANT = 1'b1
) (
  input  logic       valid_i,
  input  logic [1:0] src_i,
  input  logic       we_i,
  input  logic       sram_i,
  output logic       acc_o,
  output logic       viol_o
);
  logic wr_ok;

  generate
    if (PROG_VARIANT) begin : g_prog
      assign wr_ok = (src_i == SRC_EDMA) || (src_i == SRC_IDMA);
    end else begin : g_data
      assign wr_ok = 1'b1;
    end
  endgenerate

  logic ok;
  assign ok     = sram_i && (!we_i || wr_ok);
  assign acc_o  = valid_i && ok;
  assign viol_o = valid_i && !ok;
endmodule

// File: rtl/l1_partition_dec.sv
module l1_partition_dec #(
  parameter int AW           = 15,
  parameter int MIN_LOG2     = 12,
  parameter int MODE_W       = 3,
  parameter bit PROG_VARIANT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_src_i,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_off_i,
  output logic              acc_o,
  output logic              viol_o,
  output logic              sram_hit_o,
  output logic              cache_hit_o,
  output logic [AW-1:0]     index_o
);
  logic [MODE_W-1:0] mode_q;
  logic [AW:0]       bound;
  logic              sram_d, acc_d, viol_d;
  logic [AW-1:0]     idx_d;

  l1pd_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .mode_i(cfg_mode_i), .mode_o(mode_q)
  );

  l1pd_bound #(.AW(AW), .MIN_LOG2(MIN_LOG2), .MODE_W(MODE_W)) u_bound (
    .mode_i(mode_q), .bound_o(bound)
  );

  l1pd_region #(.AW(AW)) u_region (
    .off_i(req_off_i), .bound_i(bound), .sram_o(sram_d), .idx_o(idx_d)
  );

  l1pd_policy #(.PROG_VARIANT(PROG_VARIANT)) u_policy (
    .valid_i(req_valid_i), .src_i(req_src_i), .we_i(req_we_i),
    .sram_i(sram_d), .acc_o(acc_d), .viol_o(viol_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o       <= 1'b0;
      viol_o      <= 1'b0;
      sram_hit_o  <= 1'b0;
      cache_hit_o <= 1'b0;
      index_o     <= '0;
    end else begin
      acc_o       <= acc_d;
      viol_o      <= viol_d;
      sram_hit_o  <= req_valid_i && sram_d;
      cache_hit_o <= req_valid_i && !sram_d;
      index_o     <= req_valid_i ? idx_d : '0;
    end
  end
endmodule

// File: rtl/l1pd_checker.sv
module l1pd_checker #(
  parameter int AW           = 15,
  parameter int MODE_W       = 3,
  parameter bit PROG_VARIANT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [MODE_W-1:0] cfg_mode_i,
  input logic              req_valid_i,
  input logic [1:0]        req_src_i,
  input logic              req_we_i,
  input logic              acc_o,
  input logic              viol_o,
  input logic              sram_hit_o,
  input logic              cache_hit_o,
  input logic [MODE_W-1:0] mode_q
);
  AST_REGION_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_hit_o && cache_hit_o)); // R3

  AST_ACC_NOT_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_o && viol_o)); // R4

  AST_CACHE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_hit_o |-> (viol_o && !acc_o)); // R4

  AST_PROG_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PROG_VARIANT && req_valid_i && req_we_i && (req_src_i == 2'd0 || req_src_i == 2'd3))
      |=> (viol_o && !acc_o)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!acc_o && !viol_o && !sram_hit_o && !cache_hit_o)); // R8

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (mode_q == $past(cfg_mode_i))); // R7

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(mode_q)); // R7
endmodule

bind l1_partition_dec l1pd_checker #(
  .AW(AW), .MODE_W(MODE_W), .PROG_VARIANT(PROG_VARIANT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
  .req_valid_i(req_valid_i), .req_src_i(req_src_i), .req_we_i(req_we_i),
  .acc_o(acc_o), .viol_o(viol_o), .sram_hit_o(sram_hit_o),
  .cache_hit_o(cache_hit_o), .mode_q(mode_q)
);

// File: tb/l1_partition_dec_tb_top.sv
module l1_partition_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_mode = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_src = '0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_off = '0;

  logic p_acc, p_viol, p_sram, p_cache;
  logic d_acc, d_viol, d_sram, d_cache;
  logic [AW-1:0] p_idx, d_idx;

  int n_checks = 0;
  int n_errs = 0;
  logic [2:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1_partition_dec #(.PROG_VARIANT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .req_valid_i(req_valid), .req_src_i(req_src), .req_we_i(req_we), .req_off_i(req_off),
    .acc_o(p_acc), .viol_o(p_viol), .sram_hit_o(p_sram), .cache_hit_o(p_cache), .index_o(p_idx)
  );

  l1_partition_dec #(.PROG_VARIANT(1'b0)) dut_d_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .req_valid_i(req_valid), .req_src_i(req_src), .req_we_i(req_we), .req_off_i(req_off),
    .acc_o(d_acc), .viol_o(d_viol), .sram_hit_o(d_sram), .cache_hit_o(d_cache), .index_o(d_idx)
  );

  function automatic int bound_of(input logic [2:0] m);
    case (m)
      3'd0:    return 32768;
      3'd1:    return 32768 - 4096;
      3'd2:    return 32768 - 8192;
      3'd3:    return 32768 - 16384;
      default: return 0;
    endcase
  endfunction

  // packed {acc, viol, sram, cache, idx}
  function automatic logic [AW+3:0] expect_of(input logic [2:0] m, input logic v,
      input logic [1:0] s, input logic w, input logic [AW-1:0] o, input bit prog);
    int b = bound_of(m);
    logic sr, ok;
    logic [AW-1:0] ix;
    if (!v) return '0;
    sr = int'(o) < b;
    ix = sr ? o : AW'(int'(o) - b);
    ok = sr && (!w || !prog || s == 2'd1 || s == 2'd2);
    return {ok, !ok, sr, !sr, ix};
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic v,
      input logic [1:0] s, input logic w, input logic [AW-1:0] o, input bit prog);
    if (!v) return "R8";
    if (int'(o) >= bound_of(m)) return "R4";
    if (w && !prog && s == 2'd0) return "R9";
    if (w && prog && (s == 2'd0 || s == 2'd3)) return "R5";
    return "R6";
  endfunction

  task automatic cmp(input string tag, input logic [AW+3:0] act, input logic [AW+3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s act={acc%b viol%b sram%b cache%b idx%0d} exp={acc%b viol%b sram%b cache%b idx%0d}",
        tag, act[AW+3], act[AW+2], act[AW+1], act[AW], act[AW-1:0],
        exp[AW+3], exp[AW+2], exp[AW+1], exp[AW], exp[AW-1:0]);
    end
  endtask

  // drive at negedge, sample just after the next posedge
  task automatic step(input logic cw, input logic [2:0] cm, input logic v,
      input logic [1:0] s, input logic w, input logic [AW-1:0] o, input string tag_ovr);
    logic [AW+3:0] ep, ed;
    string tp, td;
    @(negedge clk);
    cfg_we = cw; cfg_mode = cm; req_valid = v; req_src = s; req_we = w; req_off = o;
    ep = expect_of(m_mode, v, s, w, o, 1'b1);
    ed = expect_of(m_mode, v, s, w, o, 1'b0);
    tp = (tag_ovr != "") ? tag_ovr : tag_of(m_mode, v, s, w, o, 1'b1);
    td = (tag_ovr != "") ? tag_ovr : tag_of(m_mode, v, s, w, o, 1'b0);
    if (cw) m_mode = cm;
    @(posedge clk); #1;
    cmp(tp, {p_acc, p_viol, p_sram, p_cache, p_idx}, ep);
    cmp(td, {d_acc, d_viol, d_sram, d_cache, d_idx}, ed);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [AW+3:0] z;
    int b;
    m_mode = 3'd7;
    z = '0;
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R8", {p_acc, p_viol, p_sram, p_cache, p_idx}, z);
    cmp("R8", {d_acc, d_viol, d_sram, d_cache, d_idx}, z);

    // R1: reset mode is all cache
    step(0, 0, 1, 2'd1, 0, 15'd0, "R1");
    step(0, 0, 1, 2'd2, 0, 15'h7FFF, "R1");
    // R7: write and request in same cycle use old mode, next cycle new
    step(1, 3'd0, 1, 2'd1, 1, 15'h7FFF, "R7");
    step(0, 3'd0, 1, 2'd1, 1, 15'h7FFF, "R7");
    // R5 / R9: processor write to SRAM
    step(0, 0, 1, 2'd0, 1, 15'd100, "");
    step(0, 0, 1, 2'd3, 1, 15'd200, "R5");
    step(0, 0, 1, 2'd2, 1, 15'd300, "R6");
    step(0, 0, 1, 2'd0, 0, 15'd400, "R6");
    // R2: each size, both sides of the boundary
    for (int m = 1; m < 8; m++) begin
      step(1, 3'(m), 0, 2'd0, 0, 15'd0, "R8");
      b = bound_of(3'(m));
      if (b > 0) step(0, 0, 1, 2'd1, 0, AW'(b - 1), "R2");
      if (b < 32768) step(0, 0, 1, 2'd1, 0, AW'(b), "R2");
      step(0, 0, 1, 2'd1, 0, 15'h7FFF, "R2");
    end

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic cw;
      logic [2:0] cm;
      logic [AW-1:0] o;
      int r, bb;
      cw = ($urandom % 8) == 0;
      cm = 3'($urandom);
      r  = $urandom % 4;
      bb = bound_of(m_mode);
      if (r == 0 && bb > 0) o = AW'(bb - 1);
      else if (r == 1 && bb < 32768) o = AW'(bb);
      else o = AW'($urandom);
      step(cw, cm, ($urandom % 5) != 0, 2'($urandom), 1'($urandom), o,
           cw ? "R7" : "");
    end

    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule